// File: doc/BRIEF.md
# Registered Command Pipeline Stage

This block sits on the command path between a memory controller and a group of SDRAM devices. It re-times the row strobe, column strobe, write strobe, address, bank select, the four active-low chip selects, the single clock-enable line and the eight byte-mask lines. A run-time path select chooses between a registered path and a buffered path. The registered path captures everything on one rising edge and drives it to the devices on the next. The buffered path passes the inputs straight through.

Because the registered path shifts every device-side timing by one clock, the block also reports the latencies the controller must use at the module edge. These are the module CAS latency, the read byte-mask latency and the write byte-mask latency, all derived from the path in force. A path change is accepted only when no command would be lost or repeated. A refused change leaves the path as it was and raises an error flag.

Top module: `cmdpipe_top`

## Requirements
- R1: With the registered path active, every command output equals the corresponding (deselect-gated) input sampled at the previous rising edge.
- R2: With the buffered path active, every command output follows its input in the same cycle, with no register in between.
- R3: All command fields travel with the same delay: address (13 bits), bank (2 bits), chip selects (4 bits, active low, bit n selects rank n), byte masks (8 bits, 1 = blocked), clock enable and the three strobes.
- R4: While reset is high, the path is registered and the stage holds an idle command. On the outputs this reads as all chip selects high, clock enable low, strobes high, address, bank and masks zero.
- R5: When all four chip-select inputs are high, the row, column and write strobe outputs read high (no command), whatever the strobe inputs are. The other fields still pass.
- R6: The module CAS latency output equals the device CAS latency input plus 1 on the registered path and plus 0 on the buffered path. The output is one bit wider, so device latency 7 gives 8.
- R7: The read byte-mask latency output is 3 on the registered path and 2 on the buffered path. The write byte-mask latency output is 1 and 0.
- R8: reg_mode_i (1 = registered, 0 = buffered) is compared with the active path at each rising edge. A difference is applied at that edge unless a command is pending, meaning the registered path is active and any chip-select input is low. active_reg_o shows the path in force.
- R9: A refused change keeps the active path unchanged and drives mode_err_o high for the one cycle that follows each refusing edge. Otherwise mode_err_o is low.
- R10: On the edge that switches from buffered to registered, the stage loads an idle command. For the first registered cycle all chip-select outputs read high, so the command already passed through is not issued twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| reg_mode_i | input | 1 | Requested path: 1 registered, 0 buffered |
| cs_n_i | input | 4 | Chip selects from controller, active low |
| ras_n_i | input | 1 | Row strobe from controller, active low |
| cas_n_i | input | 1 | Column strobe from controller, active low |
| we_n_i | input | 1 | Write strobe from controller, active low |
| cke_i | input | 1 | Clock enable from controller |
| bank_i | input | 2 | Bank select from controller |
| addr_i | input | 13 | Address from controller |
| dqm_i | input | 8 | Byte masks from controller, 1 blocks the byte |
| dev_cl_i | input | 3 | Device CAS latency in clocks |
| cs_n_o | output | 4 | Chip selects to devices |
| ras_n_o | output | 1 | Row strobe to devices |
| cas_n_o | output | 1 | Column strobe to devices |
| we_n_o | output | 1 | Write strobe to devices |
| cke_o | output | 1 | Clock enable fanned to all devices |
| bank_o | output | 2 | Bank select to devices |
| addr_o | output | 13 | Address to devices |
| dqm_o | output | 8 | Byte masks to devices |
| mod_cl_o | output | 4 | CAS latency seen at the module edge |
| rd_dqm_lat_o | output | 2 | Read byte-mask latency in clocks |
| wr_dqm_lat_o | output | 2 | Write byte-mask latency in clocks |
| active_reg_o | output | 1 | Path in force: 1 registered |
| mode_err_o | output | 1 | Refused path change in the previous edge |

## Verification
The bench builds the block with the package defaults: 13 address bits, 2 bank bits, 4 ranks, 8 byte lanes and a 3-bit device latency, with reset selecting the registered path. These widths let every chip-select pattern be driven, including all-high deselect and single-rank selects. Device latency 7 is reached, so the carry into the extra bit of the module latency is exercised. Both directions of path change are covered: refused with a chip select low, then accepted when idle, and the idle insertion on entry to the registered path.

// File: rtl/cmdpipe_pkg.sv
package cmdpipe_pkg;

    localparam int ADDR_W          = 13;
    localparam int BANK_W          = 2;
    localparam int RANK_N          = 4;
    localparam int BYTE_N          = 8;
    localparam int CL_W            = 3;
    localparam int LAT_W           = 2;
    // Device-side byte-mask latencies on the buffered path
    localparam int DEV_RD_MASK_LAT = 2;
    localparam int DEV_WR_MASK_LAT = 0;
    // Clocks the registered path adds
    localparam int REG_EXTRA       = 1;

    typedef enum logic {
        PATH_BUF = 1'b0,
        PATH_REG = 1'b1
    } path_e;

    typedef struct packed {
        logic [RANK_N-1:0] cs_n;
        logic              ras_n;
        logic              cas_n;
        logic              we_n;
        logic              cke;
        logic [BANK_W-1:0] bank;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_N-1:0] dqm;
    } cmd_t;

    function automatic cmd_t idle_cmd();
        cmd_t c;
        c.cs_n  = '1;
        c.ras_n = 1'b1;
        c.cas_n = 1'b1;
        c.we_n  = 1'b1;
        c.cke   = 1'b0;
        c.bank  = '0;
        c.addr  = '0;
        c.dqm   = '0;
        return c;
    endfunction

    // No rank selected: strobes are forced to the no-command state
    function automatic cmd_t gate_deselect(cmd_t c);
        cmd_t g;
        g = c;
        if (&c.cs_n) begin
            g.ras_n = 1'b1;
            g.cas_n = 1'b1;
            g.we_n  = 1'b1;
        end
        return g;
    endfunction

    function automatic logic any_rank_selected(cmd_t c);
        return ~&c.cs_n;
    endfunction

endpackage

// File: rtl/cmdpipe_mode_ctl.sv
module cmdpipe_mode_ctl
    import cmdpipe_pkg::*;
#(
    parameter path_e RESET_PATH = PATH_REG
) (
    input  logic  clk,
    input  logic  rst,
    input  path_e req_i,
    input  logic  cmd_present_i,
    output path_e path_o,
    output logic  enter_reg_o,
    output logic  err_o
);

    path_e path_q;
    logic  err_q;
    logic  differs;
    logic  blocked;

    always_comb begin
        differs     = (req_i != path_q);
        blocked     = differs && (path_q == PATH_REG) && cmd_present_i;
        enter_reg_o = differs && !blocked && (req_i == PATH_REG);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            path_q <= RESET_PATH;
            err_q  <= 1'b0;
        end else begin
            err_q <= blocked;
            if (differs && !blocked) begin
                path_q <= req_i;
            end
        end
    end

    assign path_o = path_q;
    assign err_o  = err_q;

    AST_REFUSE_KEEPS_PATH: assert property (@(posedge clk) disable iff (rst)
        (err_q && !$past(rst)) |-> (path_q == $past(path_q))); // R9

    AST_REFUSE_ONLY_REG: assert property (@(posedge clk) disable iff (rst)
        (err_q && !$past(rst)) |-> ($past(path_q) == PATH_REG)); // R8

endmodule

// File: rtl/cmdpipe_stage.sv
module cmdpipe_stage
    import cmdpipe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  path_e path_i,
    input  logic  enter_reg_i,
    input  cmd_t  cmd_i,
    output cmd_t  cmd_o
);

    cmd_t stage_q;

    always_ff @(posedge clk) begin
        if (rst || enter_reg_i) begin
            stage_q <= idle_cmd();
        end else begin
            stage_q <= cmd_i;
        end
    end

    always_comb begin
        cmd_o = (path_i == PATH_REG) ? stage_q : cmd_i;
    end

    AST_REG_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && path_i == PATH_REG && $past(path_i) == PATH_REG)
        |-> (cmd_o == $past(cmd_i))); // R1

    AST_ENTRY_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && path_i == PATH_REG && $past(path_i) == PATH_BUF)
        |-> (&cmd_o.cs_n)); // R10

endmodule

// File: rtl/cmdpipe_latency.sv
module cmdpipe_latency
    import cmdpipe_pkg::*;
(
    input  path_e             path_i,
    input  logic [CL_W-1:0]   dev_cl_i,
    output logic [CL_W:0]     mod_cl_o,
    output logic [LAT_W-1:0]  rd_lat_o,
    output logic [LAT_W-1:0]  wr_lat_o
);

    localparam logic [CL_W:0]    CL_ADD  = (CL_W+1)'(REG_EXTRA);
    localparam logic [LAT_W-1:0] RD_BUF  = LAT_W'(DEV_RD_MASK_LAT);
    localparam logic [LAT_W-1:0] WR_BUF  = LAT_W'(DEV_WR_MASK_LAT);
    localparam logic [LAT_W-1:0] RD_REG  = LAT_W'(DEV_RD_MASK_LAT + REG_EXTRA);
    localparam logic [LAT_W-1:0] WR_REG  = LAT_W'(DEV_WR_MASK_LAT + REG_EXTRA);

    always_comb begin
        if (path_i == PATH_REG) begin
            mod_cl_o = {1'b0, dev_cl_i} + CL_ADD;
            rd_lat_o = RD_REG;
            wr_lat_o = WR_REG;
        end else begin
            mod_cl_o = {1'b0, dev_cl_i};
            rd_lat_o = RD_BUF;
            wr_lat_o = WR_BUF;
        end
    end

endmodule

// File: rtl/cmdpipe_top.sv
module cmdpipe_top
    import cmdpipe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_mode_i,
    input  logic [3:0]        cs_n_i,
    input  logic              ras_n_i,
    input  logic              cas_n_i,
    input  logic              we_n_i,
    input  logic              cke_i,
    input  logic [1:0]        bank_i,
    input  logic [12:0]       addr_i,
    input  logic [7:0]        dqm_i,
    input  logic [2:0]        dev_cl_i,
    output logic [3:0]        cs_n_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic              cke_o,
    output logic [1:0]        bank_o,
    output logic [12:0]       addr_o,
    output logic [7:0]        dqm_o,
    output logic [3:0]        mod_cl_o,
    output logic [1:0]        rd_dqm_lat_o,
    output logic [1:0]        wr_dqm_lat_o,
    output logic              active_reg_o,
    output logic              mode_err_o
);

    cmd_t  raw_cmd;
    cmd_t  clean_cmd;
    cmd_t  dev_cmd;
    path_e path;
    logic  enter_reg;

    always_comb begin
        raw_cmd.cs_n  = cs_n_i;
        raw_cmd.ras_n = ras_n_i;
        raw_cmd.cas_n = cas_n_i;
        raw_cmd.we_n  = we_n_i;
        raw_cmd.cke   = cke_i;
        raw_cmd.bank  = bank_i;
        raw_cmd.addr  = addr_i;
        raw_cmd.dqm   = dqm_i;
        clean_cmd     = gate_deselect(raw_cmd);
    end

    cmdpipe_mode_ctl #(
        .RESET_PATH (PATH_REG)
    ) u_mode (
        .clk           (clk),
        .rst           (rst),
        .req_i         (path_e'(reg_mode_i)),
        .cmd_present_i (any_rank_selected(raw_cmd)),
        .path_o        (path),
        .enter_reg_o   (enter_reg),
        .err_o         (mode_err_o)
    );

    cmdpipe_stage u_stage (
        .clk         (clk),
        .rst         (rst),
        .path_i      (path),
        .enter_reg_i (enter_reg),
        .cmd_i       (clean_cmd),
        .cmd_o       (dev_cmd)
    );

    cmdpipe_latency u_lat (
        .path_i   (path),
        .dev_cl_i (dev_cl_i),
        .mod_cl_o (mod_cl_o),
        .rd_lat_o (rd_dqm_lat_o),
        .wr_lat_o (wr_dqm_lat_o)
    );

    assign cs_n_o       = dev_cmd.cs_n;
    assign ras_n_o      = dev_cmd.ras_n;
    assign cas_n_o      = dev_cmd.cas_n;
    assign we_n_o       = dev_cmd.we_n;
    assign cke_o        = dev_cmd.cke;
    assign bank_o       = dev_cmd.bank;
    assign addr_o       = dev_cmd.addr;
    assign dqm_o        = dev_cmd.dqm;
    assign active_reg_o = (path == PATH_REG);

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> ((&cs_n_o) && !cke_o && active_reg_o)); // R4

    AST_DESEL_NOP: assert property (@(posedge clk) disable iff (rst)
        (&cs_n_o) |-> (ras_n_o && cas_n_o && we_n_o)); // R5

endmodule

// File: tb/cmdpipe_top_bench.sv
module cmdpipe_top_bench;
    import cmdpipe_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = CLK_PERIOD / 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_mode_i = 1'b1;
    logic [3:0] cs_n_i = 4'hF;
    logic ras_n_i = 1'b1, cas_n_i = 1'b1, we_n_i = 1'b1, cke_i = 1'b0;
    logic [1:0] bank_i = '0;
    logic [12:0] addr_i = '0;
    logic [7:0] dqm_i = '0;
    logic [2:0] dev_cl_i = 3'd3;
    logic [3:0] cs_n_o;
    logic ras_n_o, cas_n_o, we_n_o, cke_o;
    logic [1:0] bank_o;
    logic [12:0] addr_o;
    logic [7:0] dqm_o;
    logic [3:0] mod_cl_o;
    logic [1:0] rd_dqm_lat_o, wr_dqm_lat_o;
    logic active_reg_o, mode_err_o;

    always #(HALF) clk = ~clk;

    cmdpipe_top u_cmdpipe_top (
        .clk(clk), .rst(rst), .reg_mode_i(reg_mode_i),
        .cs_n_i(cs_n_i), .ras_n_i(ras_n_i), .cas_n_i(cas_n_i), .we_n_i(we_n_i),
        .cke_i(cke_i), .bank_i(bank_i), .addr_i(addr_i), .dqm_i(dqm_i),
        .dev_cl_i(dev_cl_i),
        .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o),
        .cke_o(cke_o), .bank_o(bank_o), .addr_o(addr_o), .dqm_o(dqm_o),
        .mod_cl_o(mod_cl_o), .rd_dqm_lat_o(rd_dqm_lat_o), .wr_dqm_lat_o(wr_dqm_lat_o),
        .active_reg_o(active_reg_o), .mode_err_o(mode_err_o)
    );

    typedef struct {
        cmd_t       cmd;
        logic       err;
        logic       reg_path;
        logic [3:0] cl;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   reported = 0;

    // Bench model state
    logic m_reg;
    cmd_t m_stage;
    cmd_t m_prev;
    logic m_prev_req;

    function automatic cmd_t mk(logic [3:0] cs, logic r, logic c, logic w, logic ke,
                                logic [1:0] b, logic [12:0] a, logic [7:0] m);
        cmd_t v;
        v.cs_n = cs; v.ras_n = r; v.cas_n = c; v.we_n = w; v.cke = ke;
        v.bank = b; v.addr = a; v.dqm = m;
        return v;
    endfunction

    function automatic cmd_t model_quiet();
        return mk(4'hF, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 13'd0, 8'd0);
    endfunction

    function automatic cmd_t model_gate(cmd_t v);
        cmd_t g = v;
        if (v.cs_n == 4'hF) begin
            g.ras_n = 1'b1; g.cas_n = 1'b1; g.we_n = 1'b1;
        end
        return g;
    endfunction

    function automatic cmd_t observed();
        return mk(cs_n_o, ras_n_o, cas_n_o, we_n_o, cke_o, bank_o, addr_o, dqm_o);
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    task automatic apply(cmd_t v, logic req, logic [2:0] cl);
        cs_n_i = v.cs_n; ras_n_i = v.ras_n; cas_n_i = v.cas_n; we_n_i = v.we_n;
        cke_i = v.cke; bank_i = v.bank; addr_i = v.addr; dqm_i = v.dqm;
        reg_mode_i = req; dev_cl_i = cl;
    endtask

    // Driver: models the edge just passed, drives the next vector, queues expectation
    task automatic step(cmd_t v, logic req, logic [2:0] cl, string tag);
        logic e;
        logic enter;
        exp_t it;
        @(negedge clk);
        e = 1'b0;
        enter = 1'b0;
        if (m_prev_req != m_reg) begin
            if (m_reg && (m_prev.cs_n != 4'hF)) e = 1'b1;
            else begin
                enter = m_prev_req;
                m_reg = m_prev_req;
            end
        end
        m_stage = enter ? model_quiet() : model_gate(m_prev);
        apply(v, req, cl);
        m_prev = v;
        m_prev_req = req;
        it.cmd      = m_reg ? m_stage : model_gate(v);
        it.err      = e;
        it.reg_path = m_reg;
        it.cl       = {1'b0, cl} + {3'd0, m_reg};
        it.tag      = tag;
        exp_q.push_back(it);
    endtask

    // Monitor: samples just before each rising edge
    initial begin
        forever begin
            @(negedge clk);
            #(HALF - 1);
            if (exp_q.size() > 0) begin
                exp_t it;
                cmd_t got;
                it  = exp_q.pop_front();
                got = observed();
                chk(got == it.cmd, it.tag, "command outputs", 64'(got), 64'(it.cmd));
                chk(mode_err_o == it.err, "R9", "mode_err_o", 64'(mode_err_o), 64'(it.err));
                chk(active_reg_o == it.reg_path, "R8", "active_reg_o",
                    64'(active_reg_o), 64'(it.reg_path));
                chk(mod_cl_o == it.cl, "R6", "mod_cl_o", 64'(mod_cl_o), 64'(it.cl));
                chk(rd_dqm_lat_o == (it.reg_path ? 2'd3 : 2'd2), "R7", "rd_dqm_lat_o",
                    64'(rd_dqm_lat_o), it.reg_path ? 64'd3 : 64'd2);
                chk(wr_dqm_lat_o == (it.reg_path ? 2'd1 : 2'd0), "R7", "wr_dqm_lat_o",
                    64'(wr_dqm_lat_o), it.reg_path ? 64'd1 : 64'd0);
            end
        end
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        report();
    end

    initial begin
        cmd_t x;
        x = mk(4'b1110, 1'b0, 1'b1, 1'b1, 1'b1, 2'd3, 13'h1ABC, 8'hA5);
        // R4: selected command at the inputs during reset must not reach the outputs
        apply(x, 1'b1, 3'd3);
        repeat (3) @(negedge clk);
        #(HALF - 1);
        chk(cs_n_o == 4'hF, "R4", "cs_n_o in reset", 64'(cs_n_o), 64'hF);
        chk(cke_o == 1'b0, "R4", "cke_o in reset", 64'(cke_o), 64'h0);
        chk(ras_n_o == 1'b1 && addr_o == 13'd0, "R4", "ras_n_o/addr_o in reset",
            64'({ras_n_o, addr_o}), 64'({1'b1, 13'd0}));
        chk(active_reg_o == 1'b1, "R4", "path in reset", 64'(active_reg_o), 64'h1);
        @(negedge clk);
        rst = 1'b0;
        m_reg = 1'b1; m_stage = model_quiet(); m_prev = x; m_prev_req = 1'b1;

        // R1 / R3: registered stream, every field varied
        step(mk(4'b1101, 1'b1, 1'b0, 1'b1, 1'b1, 2'd1, 13'h0F0F, 8'h01), 1'b1, 3'd3, "R1");
        step(mk(4'b1011, 1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 13'h1FFF, 8'hFF), 1'b1, 3'd3, "R3");
        step(mk(4'b0111, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 13'h0001, 8'h80), 1'b1, 3'd2, "R3");
        step(mk(4'b0000, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 13'h1555, 8'h5A), 1'b1, 3'd7, "R1");
        // R5: deselected strobes forced idle, other fields still pass
        step(mk(4'b1111, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 13'h0AAA, 8'h3C), 1'b1, 3'd7, "R5");
        step(mk(4'b1111, 1'b0, 1'b1, 1'b0, 1'b1, 2'd1, 13'h0123, 8'hC3), 1'b1, 3'd3, "R5");
        // R9: buffered requested while a rank is selected: refused
        step(mk(4'b1110, 1'b1, 1'b0, 1'b1, 1'b1, 2'd1, 13'h0777, 8'h0F), 1'b0, 3'd3, "R9");
        step(mk(4'b1101, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 13'h0444, 8'hF0), 1'b0, 3'd3, "R9");
        // R8: request held with no rank selected: accepted
        step(mk(4'b1111, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 13'h0000, 8'h00), 1'b0, 3'd3, "R8");
        step(mk(4'b1111, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 13'h0000, 8'h00), 1'b0, 3'd3, "R8");
        // R2: buffered stream
        step(mk(4'b1110, 1'b0, 1'b1, 1'b1, 1'b1, 2'd2, 13'h1234, 8'h11), 1'b0, 3'd3, "R2");
        step(mk(4'b1011, 1'b1, 1'b0, 1'b0, 1'b1, 2'd3, 13'h0F00, 8'h22), 1'b0, 3'd7, "R2");
        step(mk(4'b1111, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 13'h00FF, 8'h44), 1'b0, 3'd2, "R5");
        step(mk(4'b0111, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 13'h1F0F, 8'h88), 1'b0, 3'd3, "R2");
        // R10: back to registered with a command at the switching edge
        step(mk(4'b1110, 1'b0, 1'b1, 1'b1, 1'b1, 2'd1, 13'h0321, 8'h12), 1'b1, 3'd3, "R10");
        step(mk(4'b1101, 1'b1, 1'b0, 1'b1, 1'b1, 2'd2, 13'h0654, 8'h34), 1'b1, 3'd3, "R10");
        step(mk(4'b1011, 1'b1, 1'b0, 1'b0, 1'b1, 2'd3, 13'h0987, 8'h56), 1'b1, 3'd7, "R1");
        step(mk(4'b1111, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 13'h0000, 8'h00), 1'b1, 3'd3, "R1");
        repeat (3) @(negedge clk);
        report();
    end

endmodule